// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block watches an SPI bus from the side and never drives it. The serial clock, both data lines and chip-select are oversampled by a faster system clock. Every watched line passes through a two-flop synchronizer, and line edges are found by comparing the newest synchronized sample with the one before it. On the sampling edge chosen by the configured clock mode, one bit is taken from each data line. When the configured number of bits has arrived, the block presents the reassembled word for each direction, together with the timestamps of the first and last bit and the word length in system-clock samples. The bit rate can be derived from that length.

The block also tracks the framing of transfers. It reports every chip-select change with the old and new levels. Right after reset it reports the starting level once, with no previous value. It pulses markers when a transfer begins and when it ends, and the end marker carries the timestamp of the matching start. Any chip-select change discards a partly received word. An option lets the block ignore chip-select while still reporting its changes. In that mode each word records whether chip-select was inactive when its first bit was sampled.

Top module: `spi_mon`

## Requirements
- R1: A bit is sampled on a rising serial-clock edge when cfg_cpol equals cfg_cpha (modes 0 and 3), and on a falling edge otherwise (modes 1 and 2).
- R2: After cfg_word_len accepted bits (1 to MAX_W), word_valid is high for exactly one cycle. The bit counter then restarts, so consecutive words are received back to back.
- R3: With cfg_lsb_first=0, the bit sampled i-th (counting from 0) is placed at word position cfg_word_len-1-i. With cfg_lsb_first=1 it is placed at position i. Bits at or above cfg_word_len read 0. This applies to word_mosi and word_miso alike.
- R4: Chip-select is active when spi_cs equals cfg_cs_high: cfg_cs_high=0 means active-low and 1 means active-high.
- R5: Each change of the synchronized chip-select level gives one cs_evt_valid pulse with cs_evt_first=0 and with cs_evt_old and cs_evt_new set to the old and new levels. After reset, exactly one event with cs_evt_first=1 and cs_evt_old=0 reports the starting level in cs_evt_new.
- R6: With cfg_cs_ignore=0, a chip-select change clears any partly received word. The next accepted bit is bit 0 of a fresh word.
- R7: With cfg_cs_ignore=0, serial-clock edges while chip-select is inactive are not accepted and produce no word.
- R8: With cfg_cs_ignore=1, edges are accepted at any chip-select level. word_cs_warn is 1 exactly when chip-select was inactive when the word's first bit was sampled.
- R9: xfer_start pulses when chip-select becomes active, including a starting level that is already active. xfer_end pulses when it becomes inactive. In both cycles xfer_start_ts holds the timestamp of the start of the current transfer.
- R10: The timestamp is a system-clock counter that is 0 in the first cycle after reset. word_start_ts and word_end_ts are the timestamps of the cycles in which the first and last bit were taken. word_dur equals word_end_ts - word_start_ts + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Observed serial clock |
| spi_mosi | input | 1 | Observed controller-to-peripheral data |
| spi_miso | input | 1 | Observed peripheral-to-controller data |
| spi_cs | input | 1 | Observed chip-select |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase (0: leading edge samples, 1: trailing edge samples) |
| cfg_lsb_first | input | 1 | 1: first bit is the least significant bit |
| cfg_cs_high | input | 1 | 1: chip-select is active-high |
| cfg_cs_ignore | input | 1 | 1: accept bits at any chip-select level and keep partial words across chip-select changes |
| cfg_word_len | input | LEN_W | Bits per word, 1 to MAX_W |
| word_valid | output | 1 | One-cycle pulse when a word is complete |
| word_mosi | output | MAX_W | Reassembled controller-to-peripheral word |
| word_miso | output | MAX_W | Reassembled peripheral-to-controller word |
| word_start_ts | output | TS_W | Timestamp of the first bit |
| word_end_ts | output | TS_W | Timestamp of the last bit |
| word_dur | output | TS_W | Word length in samples |
| word_cs_warn | output | 1 | Chip-select was inactive at the first bit |
| cs_evt_valid | output | 1 | One-cycle pulse for a chip-select event |
| cs_evt_first | output | 1 | Event reports the starting level after reset |
| cs_evt_old | output | 1 | Level before the change |
| cs_evt_new | output | 1 | Level after the change |
| xfer_start | output | 1 | One-cycle pulse when a transfer begins |
| xfer_end | output | 1 | One-cycle pulse when a transfer ends |
| xfer_start_ts | output | TS_W | Timestamp of the current transfer's start |

## Verification
A pin change made by the bench is captured by the first synchronizer flop at the next clock edge and reaches the second flop at the edge after that. The edge detector, the word assembler and the framing logic act on it during the following cycle, and their registered results appear right after the third rising clock edge. The bench model keeps a short history of pin samples and reproduces this three-edge delay behaviourally, so every expected word, chip-select event and transfer marker falls in the same cycle as the design's. The bench compares every output on the falling edge, half a cycle after the registers update. Directed checks at the end of each scenario compare word counts and word values against the data the bench itself shifted onto the bus.

// File: rtl/spi_mon_pkg.sv
// Shared helpers for the passive SPI bus monitor.
// Assumes: the clock mode is given as a polarity and phase pair.
package spi_mon_pkg;

    // The clock mode numbered by its polarity and phase pair.
    typedef enum logic [1:0] {
        SPI_MODE0 = 2'd0,
        SPI_MODE1 = 2'd1,
        SPI_MODE2 = 2'd2,
        SPI_MODE3 = 2'd3
    } spi_mode_e;

    // Returns the mode number for a polarity and phase pair.
    function automatic spi_mode_e mode_of(input logic cpol, input logic cpha);
        return spi_mode_e'({cpol, cpha});
    endfunction

    // Returns 1 when data is taken on the rising clock edge (modes 0 and 3).
    function automatic logic samples_on_rise(input logic cpol, input logic cpha);
        spi_mode_e m;
        m = mode_of(cpol, cpha);
        return (m == SPI_MODE0) || (m == SPI_MODE3);
    endfunction

endpackage

// File: rtl/spi_mon_sync.sv
// Two-flop synchronizer for W asynchronous lines, plus change detection on
// the lowest W_WATCH lines. After reset, 'prime' is high for one cycle, the
// first cycle in which the second flop holds a real sample. From the next
// cycle on, 'chg' reports any difference between the newest and previous
// synchronized samples.
// Assumes: every input is held for at least two system-clock cycles.
module spi_mon_sync #(
    parameter int W       = 4,
    parameter int W_WATCH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       din,
    output logic [W-1:0]       cur,
    output logic [W_WATCH-1:0] chg,
    output logic               prime
);
    logic [W-1:0]       meta_q, sync_q;
    logic [W_WATCH-1:0] prev_q;
    logic [1:0]         fill_q;

    // Synchronizer chain, previous-sample register and fill counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
            fill_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q[W_WATCH-1:0];
            if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
        end
    end

    // Change detection, enabled once the previous sample is real.
    always_comb begin
        cur   = sync_q;
        prime = (fill_q == 2'd2);
        chg   = (fill_q == 2'd3) ? (sync_q[W_WATCH-1:0] ^ prev_q) : '0;
    end
endmodule

// File: rtl/spi_mon_frame.sv
// Chip-select framing: activity decode, change events, the starting-level
// event and the transfer start/end markers with the start timestamp.
// Assumes: cs_high is held steady outside reset.
module spi_mon_frame #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_lvl,
    input  logic            cs_chg,
    input  logic            prime,
    input  logic            cs_high,
    input  logic [TS_W-1:0] ts,
    output logic            cs_act,
    output logic            evt_valid,
    output logic            evt_first,
    output logic            evt_old,
    output logic            evt_new,
    output logic            xfer_start,
    output logic            xfer_end,
    output logic [TS_W-1:0] xfer_start_ts
);
    // Chip-select is active when its level matches the selected polarity.
    always_comb cs_act = (cs_lvl == cs_high);

    // Event and transfer-marker registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid     <= 1'b0;
            evt_first     <= 1'b0;
            evt_old       <= 1'b0;
            evt_new       <= 1'b0;
            xfer_start    <= 1'b0;
            xfer_end      <= 1'b0;
            xfer_start_ts <= '0;
        end else begin
            evt_valid  <= 1'b0;
            xfer_start <= 1'b0;
            xfer_end   <= 1'b0;
            if (prime || cs_chg) begin
                evt_valid <= 1'b1;
                evt_first <= prime;
                evt_old   <= prime ? 1'b0 : !cs_lvl;
                evt_new   <= cs_lvl;
                if (cs_act) begin
                    xfer_start    <= 1'b1;
                    xfer_start_ts <= ts;
                end else if (cs_chg) begin
                    xfer_end <= 1'b1;
                end
            end
        end
    end

    p_marker_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_start && xfer_end));

    p_start_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (evt_valid && (evt_new == cs_high)));

    p_first_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_first) |=> !(evt_valid && evt_first));
endmodule

// File: rtl/spi_mon_word.sv
// Word assembler for two data lanes (lane 0 controller-out, lane 1
// peripheral-out). It places each accepted bit by the configured order,
// timestamps the first and last bit, measures the word length, and
// discards a partial word on a chip-select change unless chip-select is
// ignored.
// Assumes: word_len is 1..MAX_W and the configuration is steady outside reset.
module spi_mon_word #(
    parameter int MAX_W = 16,
    parameter int LEN_W = 5,
    parameter int TS_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take,
    input  logic                      cs_act,
    input  logic                      cs_chg,
    input  logic                      cs_ignore,
    input  logic                      lsb_first,
    input  logic [LEN_W-1:0]          word_len,
    input  logic [1:0]                lane_bit,
    input  logic [TS_W-1:0]           ts,
    output logic                      word_valid,
    output logic [1:0][MAX_W-1:0]     word_data,
    output logic [TS_W-1:0]           start_ts,
    output logic [TS_W-1:0]           end_ts,
    output logic [TS_W-1:0]           dur,
    output logic                      warn
);
    logic [LEN_W-1:0] bitcnt_q, cnt_base, pos;
    logic [TS_W-1:0]  first_ts_q, span_q;
    logic             warn_q, clr, accept, first, last;

    // Accept/clear decode and bit position of the current sample.
    always_comb begin
        clr      = cs_chg && !cs_ignore;
        accept   = take && (cs_act || cs_ignore);
        cnt_base = clr ? '0 : bitcnt_q;
        first    = accept && (cnt_base == '0);
        last     = accept && (cnt_base == word_len - LEN_W'(1));
        pos      = lsb_first ? cnt_base : (word_len - LEN_W'(1) - cnt_base);
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [MAX_W-1:0] sh_q, nxt, out_q;

        // Next shift-register content with the sampled bit inserted.
        always_comb begin
            nxt = clr ? '0 : sh_q;
            for (int k = 0; k < MAX_W; k++)
                if (accept && (pos == LEN_W'(k))) nxt[k] = nxt[k] | lane_bit[g];
        end

        // Shift register and the lane's word output register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q  <= '0;
                out_q <= '0;
            end else if (last) begin
                out_q <= nxt;
                sh_q  <= '0;
            end else begin
                sh_q <= nxt;
            end
        end

        assign word_data[g] = out_q;
    end

    // Bit counter, first-bit timestamp, length counter and word outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            first_ts_q <= '0;
            span_q     <= '0;
            warn_q     <= 1'b0;
            word_valid <= 1'b0;
            start_ts   <= '0;
            end_ts     <= '0;
            dur        <= '0;
            warn       <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            span_q     <= first ? TS_W'(1) : span_q + TS_W'(1);
            if (first) begin
                first_ts_q <= ts;
                warn_q     <= !cs_act;
            end
            if (last) begin
                word_valid <= 1'b1;
                start_ts   <= first ? ts : first_ts_q;
                end_ts     <= ts;
                dur        <= first ? TS_W'(1) : span_q + TS_W'(1);
                warn       <= first ? !cs_act : warn_q;
                bitcnt_q   <= '0;
            end else begin
                bitcnt_q <= accept ? cnt_base + LEN_W'(1) : cnt_base;
            end
        end
    end

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    p_dur_span_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (dur == end_ts - start_ts + TS_W'(1)));

    p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !cs_ignore) |=> (bitcnt_q == '0));
endmodule

// File: rtl/spi_mon.sv
// Passive SPI bus monitor top: synchronizes the four bus lines, selects the
// sampling edge from the clock mode, runs the timestamp counter, and joins
// the framing and word-assembly logic.
// Assumes: the system clock is at least four times the serial-clock rate.
module spi_mon #(
    parameter int MAX_W = 16,
    parameter int TS_W  = 32,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    input  logic             spi_miso,
    input  logic             spi_cs,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic             cfg_cs_high,
    input  logic             cfg_cs_ignore,
    input  logic [LEN_W-1:0] cfg_word_len,
    output logic             word_valid,
    output logic [MAX_W-1:0] word_mosi,
    output logic [MAX_W-1:0] word_miso,
    output logic [TS_W-1:0]  word_start_ts,
    output logic [TS_W-1:0]  word_end_ts,
    output logic [TS_W-1:0]  word_dur,
    output logic             word_cs_warn,
    output logic             cs_evt_valid,
    output logic             cs_evt_first,
    output logic             cs_evt_old,
    output logic             cs_evt_new,
    output logic             xfer_start,
    output logic             xfer_end,
    output logic [TS_W-1:0]  xfer_start_ts
);
    logic [3:0]            cur;
    logic [1:0]            chg;
    logic                  prime, take, cs_act;
    logic [TS_W-1:0]       ts_q;
    logic [1:0][MAX_W-1:0] lanes;

    // Free-running timestamp, 0 in the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + TS_W'(1);
    end

    // Line order: 0 clock, 1 chip-select (both watched), 2 and 3 data.
    spi_mon_sync #(.W(4), .W_WATCH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_miso, spi_mosi, spi_cs, spi_sck}),
        .cur   (cur),
        .chg   (chg),
        .prime (prime)
    );

    // Sampling-edge pulse: a clock change whose new level matches the mode.
    always_comb take = chg[0] &&
        (cur[0] == spi_mon_pkg::samples_on_rise(cfg_cpol, cfg_cpha));

    spi_mon_frame #(.TS_W(TS_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_lvl        (cur[1]),
        .cs_chg        (chg[1]),
        .prime         (prime),
        .cs_high       (cfg_cs_high),
        .ts            (ts_q),
        .cs_act        (cs_act),
        .evt_valid     (cs_evt_valid),
        .evt_first     (cs_evt_first),
        .evt_old       (cs_evt_old),
        .evt_new       (cs_evt_new),
        .xfer_start    (xfer_start),
        .xfer_end      (xfer_end),
        .xfer_start_ts (xfer_start_ts)
    );

    spi_mon_word #(.MAX_W(MAX_W), .LEN_W(LEN_W), .TS_W(TS_W)) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .cs_act     (cs_act),
        .cs_chg     (chg[1]),
        .cs_ignore  (cfg_cs_ignore),
        .lsb_first  (cfg_lsb_first),
        .word_len   (cfg_word_len),
        .lane_bit   (cur[3:2]),
        .ts         (ts_q),
        .word_valid (word_valid),
        .word_data  (lanes),
        .start_ts   (word_start_ts),
        .end_ts     (word_end_ts),
        .dur        (word_dur),
        .warn       (word_cs_warn)
    );

    assign word_mosi = lanes[0];
    assign word_miso = lanes[1];
endmodule

// File: tb/spi_mon_bench.sv
// Self-checking bench: a behavioural per-cycle model of the monitor is
// compared with every output on each falling edge, and directed checks
// compare word counts and values against the bits driven onto the bus.
module spi_mon_bench;
    localparam int MW = 16;
    localparam int LW = 5;
    localparam int TW = 32;
    localparam int H  = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_miso = 1'b0, spi_cs = 1'b1;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic cfg_cs_high = 1'b0, cfg_cs_ignore = 1'b0;
    logic [LW-1:0] cfg_word_len = LW'(8);
    logic word_valid, word_cs_warn, cs_evt_valid, cs_evt_first, cs_evt_old, cs_evt_new;
    logic xfer_start, xfer_end;
    logic [MW-1:0] word_mosi, word_miso;
    logic [TW-1:0] word_start_ts, word_end_ts, word_dur, xfer_start_ts;

    spi_mon #(.MAX_W(MW), .TS_W(TW)) u_spi_mon (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs(spi_cs), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_cs_high(cfg_cs_high), .cfg_cs_ignore(cfg_cs_ignore),
        .cfg_word_len(cfg_word_len), .word_valid(word_valid),
        .word_mosi(word_mosi), .word_miso(word_miso),
        .word_start_ts(word_start_ts), .word_end_ts(word_end_ts),
        .word_dur(word_dur), .word_cs_warn(word_cs_warn),
        .cs_evt_valid(cs_evt_valid), .cs_evt_first(cs_evt_first),
        .cs_evt_old(cs_evt_old), .cs_evt_new(cs_evt_new),
        .xfer_start(xfer_start), .xfer_end(xfer_end),
        .xfer_start_ts(xfer_start_ts)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [3:0] hist[$];
    int ts_m, mcnt, mstart;
    logic [MW-1:0] m_mo, m_mi;
    bit mwarn;
    bit e_wv, e_warn, e_ev, e_first, e_old, e_new, e_xs, e_xe;
    logic [MW-1:0] e_mo, e_mi;
    logic [TW-1:0] e_st, e_en, e_du, e_xts;

    always @(posedge clk) begin
        logic [3:0] now, old;
        bit act, chg, take, rise_mode;
        int pos;
        e_wv = 0; e_ev = 0; e_xs = 0; e_xe = 0;
        if (!rst_n) begin
            hist.delete();
            ts_m = 0; mcnt = 0; m_mo = '0; m_mi = '0;
            e_first = 0; e_old = 0; e_new = 0; e_xts = '0;
            e_mo = '0; e_mi = '0; e_st = '0; e_en = '0; e_du = '0; e_warn = 0;
        end else begin
            if (hist.size() == 2) begin
                now = hist[0];
                act = (now[1] == cfg_cs_high);
                e_ev = 1; e_first = 1; e_old = 0; e_new = now[1];
                if (act) begin e_xs = 1; e_xts = TW'(ts_m); end
            end else if (hist.size() == 3) begin
                now = hist[1]; old = hist[0];
                act = (now[1] == cfg_cs_high);
                chg = (now[1] != old[1]);
                if (chg) begin
                    e_ev = 1; e_first = 0; e_old = old[1]; e_new = now[1];
                    if (act) begin e_xs = 1; e_xts = TW'(ts_m); end
                    else e_xe = 1;
                    if (!cfg_cs_ignore) begin mcnt = 0; m_mo = '0; m_mi = '0; end
                end
                rise_mode = (cfg_cpol == cfg_cpha);
                take = (now[0] != old[0]) && (now[0] == rise_mode);
                if (take && (act || cfg_cs_ignore)) begin
                    if (mcnt == 0) begin mstart = ts_m; mwarn = !act; end
                    pos = cfg_lsb_first ? mcnt : int'(cfg_word_len) - 1 - mcnt;
                    m_mo[pos] = now[2];
                    m_mi[pos] = now[3];
                    mcnt++;
                    if (mcnt == int'(cfg_word_len)) begin
                        e_wv = 1; e_mo = m_mo; e_mi = m_mi;
                        e_st = TW'(mstart); e_en = TW'(ts_m);
                        e_du = TW'(ts_m - mstart + 1); e_warn = mwarn;
                        mcnt = 0; m_mo = '0; m_mi = '0;
                    end
                end
            end
            hist.push_back({spi_miso, spi_mosi, spi_cs, spi_sck});
            if (hist.size() > 3) void'(hist.pop_front());
            ts_m++;
        end
    end

    // ---------------- per-cycle comparison and monitors ----------------
    int n_words = 0, n_xe = 0, n_first = 0;
    logic [MW-1:0] last_mo, last_mi;
    bit last_warn;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(word_valid == e_wv, "R2 word_valid timing", 64'(word_valid), 64'(e_wv));
            if (word_valid && e_wv) begin
                chk(word_mosi == e_mo, "R3 word_mosi", 64'(word_mosi), 64'(e_mo));
                chk(word_miso == e_mi, "R3 word_miso", 64'(word_miso), 64'(e_mi));
                chk(word_start_ts == e_st, "R10 word_start_ts", 64'(word_start_ts), 64'(e_st));
                chk(word_end_ts == e_en, "R10 word_end_ts", 64'(word_end_ts), 64'(e_en));
                chk(word_dur == e_du, "R10 word_dur", 64'(word_dur), 64'(e_du));
                chk(word_cs_warn == e_warn, "R8 word_cs_warn", 64'(word_cs_warn), 64'(e_warn));
            end
            chk(cs_evt_valid == e_ev, "R5 cs_evt_valid", 64'(cs_evt_valid), 64'(e_ev));
            if (cs_evt_valid && e_ev)
                chk({cs_evt_first, cs_evt_old, cs_evt_new} == {e_first, e_old, e_new},
                    "R5 cs event fields", 64'({cs_evt_first, cs_evt_old, cs_evt_new}),
                    64'({e_first, e_old, e_new}));
            chk({xfer_start, xfer_end} == {e_xs, e_xe}, "R9 transfer markers",
                64'({xfer_start, xfer_end}), 64'({e_xs, e_xe}));
            if (e_xs || e_xe)
                chk(xfer_start_ts == e_xts, "R9 xfer_start_ts", 64'(xfer_start_ts), 64'(e_xts));
            if (word_valid) begin
                n_words++; last_mo = word_mosi; last_mi = word_miso; last_warn = word_cs_warn;
            end
            if (xfer_end) n_xe++;
            if (cs_evt_valid && cs_evt_first) n_first++;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit cpol, input bit cpha, input bit lsb,
                            input bit csh, input bit ign, input int len);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        cfg_cs_high = csh; cfg_cs_ignore = ign; cfg_word_len = LW'(len);
        spi_sck = cpol; spi_cs = !csh; spi_mosi = 1'b0; spi_miso = 1'b0;
        wait_n(4);
        chk(!word_valid && !cs_evt_valid && !xfer_start && !xfer_end,
            "R2 reset state", 64'({word_valid, cs_evt_valid, xfer_start, xfer_end}), 64'(0));
        n_words = 0; n_xe = 0; n_first = 0;
        rst_n = 1'b1;
        wait_n(8);
        chk(n_first == 1, "R5 single starting-level event", 64'(n_first), 64'(1));
    endtask

    task automatic cs_set(input bit active);
        spi_cs = active ? cfg_cs_high : !cfg_cs_high;
        wait_n(6);
    endtask

    task automatic send_word(input logic [MW-1:0] mo, input logic [MW-1:0] mi, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            int idx;
            idx = cfg_lsb_first ? i : int'(cfg_word_len) - 1 - i;
            if (!cfg_cpha) begin
                spi_mosi = mo[idx]; spi_miso = mi[idx];
                wait_n(H); spi_sck = !spi_sck;
                wait_n(H); spi_sck = !spi_sck;
            end else begin
                spi_sck = !spi_sck; spi_mosi = mo[idx]; spi_miso = mi[idx];
                wait_n(H); spi_sck = !spi_sck;
                wait_n(H);
            end
        end
        wait_n(4);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        // Mode 0, MSB first, 8 bits, active-low.
        do_reset(0, 0, 0, 0, 0, 8);
        cs_set(1);
        send_word(16'h00A5, 16'h003C, 8);
        send_word(16'h000F, 16'h00F0, 8);
        cs_set(0);
        chk(n_words == 2, "R1 mode 0 word count", 64'(n_words), 64'(2));
        chk(last_mo == 16'h000F && last_mi == 16'h00F0, "R3 msb-first value",
            64'({last_mo, last_mi}), 64'({16'h000F, 16'h00F0}));
        chk(n_xe == 1, "R9 one transfer end", 64'(n_xe), 64'(1));

        // Mode 1, LSB first, 12 bits.
        do_reset(0, 1, 1, 0, 0, 12);
        cs_set(1);
        send_word(16'h0ABC, 16'h0123, 12);
        cs_set(0);
        chk(n_words == 1, "R1 mode 1 word count", 64'(n_words), 64'(1));
        chk(last_mo == 16'h0ABC && last_mi == 16'h0123, "R3 lsb-first value",
            64'({last_mo, last_mi}), 64'({16'h0ABC, 16'h0123}));

        // Mode 2, MSB first, 5 bits, active-high chip-select.
        do_reset(1, 0, 0, 1, 0, 5);
        cs_set(1);
        send_word(16'h0013, 16'h000A, 5);
        cs_set(0);
        chk(n_words == 1, "R4 active-high word count", 64'(n_words), 64'(1));
        chk(last_mo == 16'h0013, "R4 active-high value", 64'(last_mo), 64'(16'h0013));

        // Mode 3, LSB first, full 16 bits.
        do_reset(1, 1, 1, 0, 0, 16);
        cs_set(1);
        send_word(16'hBEEF, 16'h1234, 16);
        cs_set(0);
        chk(n_words == 1 && last_mo == 16'hBEEF, "R1 mode 3 word",
            64'({n_words[15:0], last_mo}), 64'({16'd1, 16'hBEEF}));

        // Partial word dropped by a chip-select change.
        do_reset(0, 0, 0, 0, 0, 8);
        cs_set(1);
        send_word(16'h00FF, 16'h00FF, 3);
        cs_set(0);
        cs_set(1);
        send_word(16'h0081, 16'h0042, 8);
        cs_set(0);
        chk(n_words == 1, "R6 partial word discarded", 64'(n_words), 64'(1));
        chk(last_mo == 16'h0081 && last_mi == 16'h0042, "R6 fresh word value",
            64'({last_mo, last_mi}), 64'({16'h0081, 16'h0042}));

        // Clock activity while chip-select is inactive.
        do_reset(0, 0, 0, 0, 0, 8);
        send_word(16'h00AA, 16'h0055, 8);
        chk(n_words == 0, "R7 idle clock ignored", 64'(n_words), 64'(0));
        cs_set(1);
        send_word(16'h003C, 16'h00C3, 8);
        cs_set(0);
        chk(n_words == 1 && last_mo == 16'h003C, "R7 word after idle clocks",
            64'({n_words[15:0], last_mo}), 64'({16'd1, 16'h003C}));

        // Chip-select ignored: warning flag follows the first-bit level.
        do_reset(0, 0, 0, 0, 1, 8);
        send_word(16'h0099, 16'h0011, 8);
        chk(n_words == 1 && last_warn, "R8 warn when inactive",
            64'({n_words[15:0], 15'd0, last_warn}), 64'({16'd1, 16'd1}));
        cs_set(1);
        send_word(16'h0066, 16'h0022, 8);
        chk(n_words == 2 && !last_warn && last_mo == 16'h0066, "R8 no warn when active",
            64'({n_words[15:0], last_mo, 15'd0, last_warn}), 64'({16'd2, 16'h0066, 16'd0}));
        cs_set(0);

        // Single-bit words.
        do_reset(0, 0, 0, 0, 0, 1);
        cs_set(1);
        send_word(16'h0001, 16'h0000, 1);
        send_word(16'h0000, 16'h0001, 1);
        cs_set(0);
        chk(n_words == 2 && last_mi == 16'h0001, "R2 one-bit words",
            64'({n_words[15:0], last_mi}), 64'({16'd2, 16'h0001}));

        wait_n(10);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule